// File: doc/BRIEF.md
# Ring-Buffer Sample Memory Address Generator

This block turns the address fields of a signal-processing microinstruction into a byte address for the external sample memory, and keeps the per-sample ring position counter that makes delay lines circulate. A word address is formed from a selectable base register and two optional increments: the low bits of an address offset register, and a "next word" increment. In ring mode the current ring position is added and the sum wraps inside a power-of-two ring. In table mode the sum is held to 16 bits and the ring position plays no part. The word address is then doubled into a byte address, offset by a ring base byte address, and folded into a 2 MB or an 8 MB space chosen by parameter.

The microprogram runs in passes of 128 steps. Memory requests are allowed only on odd steps. The block registers each request together with two slot numbers. One gives the slot of a four-entry read buffer that the returning data will fill, two steps ahead. The other gives the slot that an input-write on this step copies from. At the end of every pass the ring counter counts down by one, and when it would reach zero it is reloaded with the ring length plus one.

Top module: `dsp_ring_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `ring_ct` is 1, the ring mask is 0x7FFF, the ring base is 0, all base registers are 0, and `mem_rd_en` and `mem_wr_en` are low.
- R2: The word address starts from base register `base_sel`, written earlier through `base_wr_en`/`base_wr_idx`/`base_wr_data`. When `add_offset` is 1, `offset_lo` (12 bits) is added.
- R3: When `add_next` is 1, one is added to the word address.
- R4: With `table_mode` 0, the current `ring_ct` is added and the sum is ANDed with the ring mask. The mask, loaded by `cfg_wr_en` from `cfg_ring_len`, must have the form 2^n-1.
- R5: With `table_mode` 1, the word sum is cut to its low 16 bits and `ring_ct` has no effect on the address.
- R6: `mem_addr` equals the word address shifted left by one, plus the ring base (`cfg_ring_base`), kept to 21 bits (8 MB variant: 23 bits).
- R7: A request on a step whose `step_lsb[0]` is 0 produces neither `mem_rd_en` nor `mem_wr_en`.
- R8: On a valid step with step number s, `rd_slot` becomes (s+2) mod 4 and `iw_slot` becomes s mod 4.
- R9: Each `pass_end` pulse decrements `ring_ct`. A pulse when `ring_ct` is 1 reloads it with the ring mask plus one. Without a pulse, `ring_ct` holds.
- R10: Request outputs are registered: they appear in the cycle after `step_valid`, and both enables are low in the cycle after a cycle without `step_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Write one base register |
| base_wr_idx | input | 5 | Base register index to write |
| base_wr_data | input | 16 | Base register write value (word address) |
| cfg_wr_en | input | 1 | Load ring mask and ring base |
| cfg_ring_len | input | 16 | Ring mask, 2^n-1 |
| cfg_ring_base | input | 21 | Ring base byte address |
| step_valid | input | 1 | A microinstruction step is presented |
| step_lsb | input | 2 | Low two bits of the step number |
| base_sel | input | 5 | Base register selector |
| add_offset | input | 1 | Add the offset field |
| add_next | input | 1 | Add one word |
| table_mode | input | 1 | Table access, no ring wrap |
| offset_lo | input | 12 | Low bits of the address offset register |
| req_rd | input | 1 | Step requests a memory read |
| req_wr | input | 1 | Step requests a memory write |
| pass_end | input | 1 | End of a 128-step pass |
| mem_rd_en | output | 1 | Registered read request |
| mem_wr_en | output | 1 | Registered write request |
| mem_addr | output | 21 | Registered byte address |
| rd_slot | output | 2 | Read buffer slot for the returned data |
| iw_slot | output | 2 | Read buffer slot for an input-write |
| ring_ct | output | 17 | Ring position counter |

## Verification
The hardest case to reach is the reload of the ring counter. With the reset ring mask, the counter would have to count down through 32768 passes before a reload repeats. The stimulus therefore first loads a small mask (3) and then sends a train of pass-end pulses, so the counter goes through reload, countdown and reload again within a few cycles. Table-mode accesses are then issued at a nonzero counter value to show that the counter does not reach the address. A ring base near the top of the 2 MB space drives the byte address past the fold point.

// File: rtl/dsp_ring_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the ring-buffer address generator.
// Assumes the slot buffer always has four entries (two-bit slot numbers).
package dsp_ring_pkg;
    localparam int SLOT_W    = 2;
    localparam int RD_LEAD   = 2;   // read data lands this many steps ahead

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [SLOT_W-1:0] rd_slot;
        logic [SLOT_W-1:0] iw_slot;
    } slot_req_t;

    // Byte space width for the chosen memory size
    function automatic int space_bits(input bit big);
        return big ? 23 : 21;
    endfunction
endpackage

// File: rtl/ring_base_bank.sv
`timescale 1ns/1ps
// Module: ring_base_bank
// Holds the word-address base registers and gives the one selected by
// the current step. One synchronous write port, one combinational read.
// Assumes index values stay below NUM.
module ring_base_bank #(
    parameter int NUM   = 32,
    parameter int W     = 16,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] regs_q [NUM];

    genvar gi;
    generate
        for (gi = 0; gi < NUM; gi++) begin : g_entry
            // Per-entry storage: cleared at reset, loaded on matching write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[gi] <= '0;
                else if (wr_en && (wr_idx == IDX_W'(gi)))
                    regs_q[gi] <= wr_data;
            end
        end
    endgenerate

    // Read mux for the step's selector
    always_comb begin
        rd_data = regs_q[rd_idx];
    end
endmodule

// File: rtl/ring_pos_counter.sv
`timescale 1ns/1ps
// Module: ring_pos_counter
// Per-sample ring position. Counts down once per pass; a pass ending at
// value 1 reloads mask+1 so the counter never rests at zero.
// Assumes the mask is of the form 2^n-1.
module ring_pos_counter #(
    parameter int RING_W = 16,
    localparam int CT_W = RING_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_end,
    input  logic [RING_W-1:0] ring_mask,
    output logic [CT_W-1:0]   ct
);
    logic [CT_W-1:0] ct_q;

    // Countdown with reload at the bottom of the range
    always_ff @(posedge clk) begin
        if (!rst_n)
            ct_q <= CT_W'(1);
        else if (pass_end) begin
            if (ct_q == CT_W'(1))
                ct_q <= CT_W'(ring_mask) + CT_W'(1);
            else
                ct_q <= ct_q - CT_W'(1);
        end
    end

    assign ct = ct_q;

    assert_ct_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q != '0);
    assert_ct_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_end && ct_q == CT_W'(1)) |=> (ct_q == CT_W'($past(ring_mask)) + CT_W'(1)));
    assert_ct_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_end |=> $stable(ct_q));
endmodule

// File: rtl/ring_addr_calc.sv
`timescale 1ns/1ps
// Module: ring_addr_calc
// Combinational word-to-byte address path: base + optional offset +
// optional next-word, then ring wrap or table cut, then doubling, ring
// base add and fold into the memory space.
// Assumes ADDR_W > RING_W so the doubled word fits before the base add.
module ring_addr_calc #(
    parameter int RING_W = 16,
    parameter int OFS_W  = 12,
    parameter int ADDR_W = 21
) (
    input  logic [RING_W-1:0] base,
    input  logic [OFS_W-1:0]  offset,
    input  logic              add_offset,
    input  logic              add_next,
    input  logic              table_mode,
    input  logic [RING_W-1:0] ring_ct,
    input  logic [RING_W-1:0] ring_mask,
    input  logic [ADDR_W-1:0] ring_base,
    output logic [ADDR_W-1:0] byte_addr
);
    logic [RING_W-1:0] part_sum;
    logic [RING_W-1:0] word_addr;

    // Sum of base and the optional increments, modulo 2^RING_W
    always_comb begin
        part_sum = base;
        if (add_offset) part_sum = part_sum + RING_W'(offset);
        if (add_next)   part_sum = part_sum + RING_W'(1);
    end

    // Ring wrap or table cut
    always_comb begin
        if (table_mode)
            word_addr = part_sum;
        else
            word_addr = (part_sum + ring_ct) & ring_mask;
    end

    // Word to byte, add base, fold into the memory space
    always_comb begin
        byte_addr = ADDR_W'({word_addr, 1'b0}) + ring_base;
    end
endmodule

// File: rtl/ring_slot_sched.sv
`timescale 1ns/1ps
// Module: ring_slot_sched
// Registers each step's memory request and its buffer slot numbers.
// Requests on even steps are dropped; reads fill a slot two steps ahead.
// Assumes step_lsb carries the low bits of the step number.
module ring_slot_sched
    import dsp_ring_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic [SLOT_W-1:0] step_lsb,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] addr_in,
    output slot_req_t         req_q,
    output logic [ADDR_W-1:0] addr_q
);
    slot_req_t nxt;

    // Next request: access only on odd steps
    always_comb begin
        nxt.rd      = step_valid && step_lsb[0] && req_rd;
        nxt.wr      = step_valid && step_lsb[0] && req_wr;
        nxt.rd_slot = req_q.rd_slot;
        nxt.iw_slot = req_q.iw_slot;
        if (step_valid) begin
            nxt.rd_slot = step_lsb + SLOT_W'(RD_LEAD);
            nxt.iw_slot = step_lsb;
        end
    end

    // Request and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            addr_q <= '0;
        end else begin
            req_q <= nxt;
            if (step_valid) addr_q <= addr_in;
        end
    end

    assert_slot_lead_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_q.rd |-> (req_q.rd_slot == req_q.iw_slot + SLOT_W'(RD_LEAD)));
    assert_odd_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q.rd || req_q.wr) |-> req_q.iw_slot[0]);
endmodule

// File: rtl/dsp_ring_addr_gen.sv
`timescale 1ns/1ps
// Module: dsp_ring_addr_gen (top)
// Sample memory address generator for a microprogrammed audio DSP.
// Holds the ring mask and ring base, the base register bank and the
// ring position counter, and issues registered memory requests.
// Assumes the ring mask written is always 2^n-1.
module dsp_ring_addr_gen
    import dsp_ring_pkg::*;
#(
    parameter int  NUM_BASE = 32,
    parameter int  RING_W   = 16,
    parameter int  OFS_W    = 12,
    parameter bit  MEM_8MB  = 1'b0,
    localparam int SEL_W    = $clog2(NUM_BASE),
    localparam int ADDR_W   = space_bits(MEM_8MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [SEL_W-1:0]  base_wr_idx,
    input  logic [RING_W-1:0] base_wr_data,
    input  logic              cfg_wr_en,
    input  logic [RING_W-1:0] cfg_ring_len,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic              step_valid,
    input  logic [1:0]        step_lsb,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic              add_offset,
    input  logic              add_next,
    input  logic              table_mode,
    input  logic [OFS_W-1:0]  offset_lo,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              pass_end,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        rd_slot,
    output logic [1:0]        iw_slot,
    output logic [RING_W:0]   ring_ct
);
    localparam logic [RING_W-1:0] MASK_RST = RING_W'((1 << (RING_W - 1)) - 1);

    logic [RING_W-1:0] ring_mask_q;
    logic [ADDR_W-1:0] ring_base_q;
    logic [RING_W-1:0] base_word;
    logic [ADDR_W-1:0] byte_addr;
    slot_req_t         req_q;

    // Ring mask and ring base configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_mask_q <= MASK_RST;
            ring_base_q <= '0;
        end else if (cfg_wr_en) begin
            ring_mask_q <= cfg_ring_len;
            ring_base_q <= cfg_ring_base;
        end
    end

    ring_base_bank #(.NUM(NUM_BASE), .W(RING_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_idx  (base_wr_idx),
        .wr_data (base_wr_data),
        .rd_idx  (base_sel),
        .rd_data (base_word)
    );

    ring_pos_counter #(.RING_W(RING_W)) u_ct (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_end  (pass_end),
        .ring_mask (ring_mask_q),
        .ct        (ring_ct)
    );

    ring_addr_calc #(.RING_W(RING_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_calc (
        .base       (base_word),
        .offset     (offset_lo),
        .add_offset (add_offset),
        .add_next   (add_next),
        .table_mode (table_mode),
        .ring_ct    (ring_ct[RING_W-1:0]),
        .ring_mask  (ring_mask_q),
        .ring_base  (ring_base_q),
        .byte_addr  (byte_addr)
    );

    ring_slot_sched #(.ADDR_W(ADDR_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .step_lsb   (step_lsb),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .addr_in    (byte_addr),
        .req_q      (req_q),
        .addr_q     (mem_addr)
    );

    // Output breakout
    always_comb begin
        mem_rd_en = req_q.rd;
        mem_wr_en = req_q.wr;
        rd_slot   = req_q.rd_slot;
        iw_slot   = req_q.iw_slot;
    end

    assert_mask_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |-> ((cfg_ring_len & (cfg_ring_len + RING_W'(1))) == '0));
    assert_even_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_lsb[0]) |=> (!mem_rd_en && !mem_wr_en));
    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> (!mem_rd_en && !mem_wr_en));
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> $stable(mem_addr));
endmodule

// File: tb/dsp_ring_addr_gen_test.sv
`timescale 1ns/1ps
module dsp_ring_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_wr_en;
    logic [4:0]  base_wr_idx;
    logic [15:0] base_wr_data;
    logic        cfg_wr_en;
    logic [15:0] cfg_ring_len;
    logic [20:0] cfg_ring_base;
    logic        step_valid;
    logic [1:0]  step_lsb;
    logic [4:0]  base_sel;
    logic        add_offset, add_next, table_mode;
    logic [11:0] offset_lo;
    logic        req_rd, req_wr, pass_end;
    logic        mem_rd_en, mem_wr_en;
    logic [20:0] mem_addr;
    logic [1:0]  rd_slot, iw_slot;
    logic [16:0] ring_ct;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    int m_base [32];
    int m_mask = 'h7FFF;
    int m_rbp  = 0;
    int m_ct   = 1;

    always #4 clk = ~clk;

    dsp_ring_addr_gen uut (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_idx(base_wr_idx), .base_wr_data(base_wr_data),
        .cfg_wr_en(cfg_wr_en), .cfg_ring_len(cfg_ring_len), .cfg_ring_base(cfg_ring_base),
        .step_valid(step_valid), .step_lsb(step_lsb), .base_sel(base_sel),
        .add_offset(add_offset), .add_next(add_next), .table_mode(table_mode),
        .offset_lo(offset_lo), .req_rd(req_rd), .req_wr(req_wr), .pass_end(pass_end),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .rd_slot(rd_slot), .iw_slot(iw_slot), .ring_ct(ring_ct)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic int exp_addr(int sel, int ofs, bit ao, bit an, bit tb);
        int w;
        w = m_base[sel] + (ao ? (ofs & 'hFFF) : 0) + (an ? 1 : 0);
        if (tb) w = w & 'hFFFF;
        else    w = (w + m_ct) & m_mask;
        return ((w << 1) + m_rbp) & 'h1FFFFF;
    endfunction

    task automatic idle_inputs();
        base_wr_en = 0; base_wr_idx = 0; base_wr_data = 0;
        cfg_wr_en = 0; cfg_ring_len = 0; cfg_ring_base = 0;
        step_valid = 0; step_lsb = 0; base_sel = 0;
        add_offset = 0; add_next = 0; table_mode = 0; offset_lo = 0;
        req_rd = 0; req_wr = 0; pass_end = 0;
    endtask

    task automatic write_base(input int idx, input int val);
        @(negedge clk);
        base_wr_en = 1; base_wr_idx = idx[4:0]; base_wr_data = val[15:0];
        @(negedge clk);
        base_wr_en = 0;
        m_base[idx] = val & 'hFFFF;
    endtask

    task automatic write_cfg(input int mask, input int rbp);
        @(negedge clk);
        cfg_wr_en = 1; cfg_ring_len = mask[15:0]; cfg_ring_base = rbp[20:0];
        @(negedge clk);
        cfg_wr_en = 0;
        m_mask = mask; m_rbp = rbp;
    endtask

    // Present one step, check registered outputs one cycle later
    task automatic run_step(input string req, input int s, input int sel, input int ofs,
                            input bit ao, input bit an, input bit tb, input bit rd, input bit wr);
        int ea;
        bit odd;
        @(negedge clk);
        ea = exp_addr(sel, ofs, ao, an, tb);
        odd = s[0];
        step_valid = 1; step_lsb = s[1:0]; base_sel = sel[4:0];
        offset_lo = ofs[11:0]; add_offset = ao; add_next = an; table_mode = tb;
        req_rd = rd; req_wr = wr;
        @(negedge clk);
        chk({req, " rd_en"}, int'(mem_rd_en), int'(rd && odd));
        chk({req, " wr_en"}, int'(mem_wr_en), int'(wr && odd));
        chk({req, " addr"}, int'(mem_addr), ea);
        chk({req, " R8 rd_slot"}, int'(rd_slot), (s + 2) & 3);
        chk({req, " R8 iw_slot"}, int'(iw_slot), s & 3);
        step_valid = 0; req_rd = 0; req_wr = 0;
    endtask

    task automatic pulse_pass(input string req);
        @(negedge clk);
        pass_end = 1;
        @(negedge clk);
        pass_end = 0;
        if (m_ct == 1) m_ct = m_mask + 1;
        else           m_ct = m_ct - 1;
        chk({req, " ring_ct"}, int'(ring_ct), m_ct);
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ring_ct", int'(ring_ct), 1);
        chk("R1 rd_en", int'(mem_rd_en), 0);
        chk("R1 wr_en", int'(mem_wr_en), 0);
        // base 7 reset value and default mask/base seen through an access
        run_step("R1 default state", 1, 7, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_ring_basic();
        write_base(3, 'h0100);
        run_step("R4 ring read", 1, 3, 0, 0, 0, 0, 1, 0);
        run_step("R2 offset add", 3, 3, 'hF23, 1, 0, 0, 0, 1);
        run_step("R3 next word", 1, 3, 'h123, 1, 1, 0, 1, 1);
        run_step("R2 offset ignored when off", 3, 3, 'hABC, 0, 0, 0, 1, 0);
    endtask

    task automatic t_even_idle();
        run_step("R7 even step", 2, 3, 0, 0, 0, 0, 1, 1);
        run_step("R7 even step 0", 0, 3, 0, 0, 0, 0, 1, 1);
        @(negedge clk);
        req_rd = 1; req_wr = 1; step_lsb = 1;
        @(negedge clk);
        chk("R10 idle rd_en", int'(mem_rd_en), 0);
        chk("R10 idle wr_en", int'(mem_wr_en), 0);
        req_rd = 0; req_wr = 0;
    endtask

    task automatic t_wrap_fold();
        write_cfg('h00FF, 'h1000);
        write_base(9, 'h01F0);
        run_step("R4 ring wrap", 3, 9, 'h20, 1, 0, 0, 1, 0);
        write_cfg('h7FFF, 'h1FFFFE);
        write_base(4, 'h0001);
        run_step("R6 space fold", 1, 4, 0, 0, 1, 0, 1, 0);
    endtask

    task automatic t_counter();
        write_cfg('h0003, 0);
        pulse_pass("R9 reload from 1");
        pulse_pass("R9 decrement");
        pulse_pass("R9 decrement");
        pulse_pass("R9 decrement to 1");
        pulse_pass("R9 reload again");
        repeat (3) @(negedge clk);
        chk("R9 hold", int'(ring_ct), m_ct);
    endtask

    task automatic t_table();
        write_cfg('h7FFF, 'h0040);
        pulse_pass("R9 to 3");
        write_base(5, 'hFFFF);
        run_step("R5 table cut", 1, 5, 0, 0, 1, 1, 1, 0);
        write_base(6, 'h9000);
        run_step("R5 table no ring", 3, 6, 'h010, 1, 0, 1, 0, 1);
        run_step("R4 ring uses ct", 3, 6, 'h010, 1, 0, 0, 0, 1);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_base[i] = 0;
        t_reset();
        t_ring_basic();
        t_even_idle();
        t_wrap_fold();
        t_counter();
        t_table();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule